// File: doc/BRIEF.md
# Dual-Channel Byte Mover

This block is a two-channel DMA engine for an 8-bit CPU bus. Each channel has a 16-bit source address, a 16-bit destination address and a 16-bit transfer count. Each of these working registers has a shadow latch behind it. CPU software programs the channels through a small byte-wide register window. A single index bit in the shared status register selects which channel's registers appear in that window. A request-capture block outside this one sends a one-cycle request strobe per channel. The engine then asks for the system bus, waits for a grant, reads one byte at the source address, writes it to the destination address and gives the bus back.

After each byte the addresses step up, step down or hold, and the count decrements. A transfer made while the count is already zero is an underflow. On underflow the engine sets a sticky flag and reloads the count from its latch. It also reloads the addresses from their latches unless a global inhibit bit is set. Optionally the channel disables itself. In cycle-steal mode a channel moves one byte per request. In burst mode one request runs the channel to underflow. While the CPU is servicing an interrupt, burst channels pause; a policy bit can make cycle-steal channels pause as well.

Top module: `dma2ch_engine`

Register window (cpu_addr). 0: status/control. Bit0 is the ch0 underflow flag and bit2 the ch1 underflow flag; writing 0 to a flag clears it and writing 1 leaves it unchanged. Bit1 and bit3 are the ch0/ch1 suspended flags (read-only). Bit4 is suspend-all. Bit5 is reload-inhibit. Bit7 is the channel index. 1: mode of the indexed channel. Bit0 is source direction (0 up, 1 down), bit1 source update enable, bit2 destination direction, bit3 destination update enable, bit4 latch-only writes, bit5 stop on underflow, bit6 reload (write 1, reads 0), bit7 burst. 2: bit0 channel enable. 4/5: source low/high byte. 8/9: destination low/high byte. 12/13: count low/high byte. Reads of 4..13 return the working registers.

## Requirements
- R1: After reset the status register reads 0x00, both channels are disabled and bus_req is low.
- R2: Writes and reads at addresses 1..13 reach only the channel named by status bit7; the other channel's registers keep their values.
- R3: In cycle-steal mode each request strobe to an enabled channel moves exactly one byte: a read at the source address, then a write of that byte at the destination address.
- R4: After each byte an address with its update-enable bit at 1 steps by +1 when its direction bit is 0 and by -1 when it is 1; with update-enable at 0 it is unchanged. The count decrements by 1.
- R5: With mode bit4 at 1, CPU writes to the source, destination or count bytes change only the latch; reads still return the old working value.
- R6: Writing mode bit6 as 1 copies all three latches into the working registers, and bit6 reads back as 0.
- R7: A byte moved with the count at 0 sets that channel's underflow flag and reloads the count, source and destination from their latches. Writing 0 to the flag clears it.
- R8: With mode bit5 at 1, underflow clears the channel enable, and later requests to that channel move nothing. With bit5 at 0 the channel stays enabled.
- R9: In burst mode one request moves count+1 bytes back to back and stops at underflow.
- R10: With status bit5 at 1, underflow reloads only the count; source and destination keep their stepped values.
- R11: When both channels are pending, channel 0 is served first, and a running burst is never interleaved with the other channel.
- R12: While irq_busy is high, a burst channel (and with status bit4 at 1 also a cycle-steal channel) starts no new byte, and its suspended flag reads 1 while it has work waiting. It resumes when irq_busy falls.
- R13: bus_req rises before any bus cycle and stays high while bus_gnt is low; no read starts without a grant, and bus_req falls after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| dma_req | input | 2 | Per-channel one-cycle request strobe |
| irq_busy | input | 1 | High while the CPU services an interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled at the end of the read cycle |

## Verification
The hardest state to reach is a suspended channel with work waiting while the other channel keeps running. To get there the bench raises irq_busy and then strobes both channels together, with a burst channel on ch0 and a cycle-steal channel on ch1. It checks that only ch1's byte lands and that ch0's suspended flag reads 1. It then sets suspend-all and strobes ch1 again so that ch1 is also held. After irq_busy drops it checks that every held transfer completes. Ordering against a running burst is observed by recording the sequence of bus writes in the memory stub.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OFS_STAT = 4'd0;
  localparam logic [3:0] OFS_MODE = 4'd1;
  localparam logic [3:0] OFS_CTRL = 4'd2;

  localparam logic [1:0] RGN_MISC = 2'd0;
  localparam logic [1:0] RGN_SRC  = 2'd1;
  localparam logic [1:0] RGN_DST  = 2'd2;
  localparam logic [1:0] RGN_CNT  = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RD, SQ_WR} seq_state_e;

  typedef struct packed {
    logic burst;
    logic stop_uf;
    logic latch_only;
    logic dst_upd;
    logic dst_dir;
    logic src_upd;
    logic src_dir;
  } chan_mode_t;

  function automatic logic [7:0] get_byte(logic [31:0] v, logic [1:0] i);
    return v[{i, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] put_byte(logic [31:0] v, logic [1:0] i, logic [7:0] b);
    logic [31:0] r;
    r = v;
    r[{i, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              step,
  input  logic              inhibit,
  input  logic              uf_clr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              cnt_zero,
  output logic              en_o,
  output logic              burst_o,
  output logic              uf_o
);
  localparam int AW_PAD = 32 - ADDR_W;
  localparam int CW_PAD = 32 - CNT_W;

  chan_mode_t        mode_q, mode_n;
  logic              en_q, en_n, uf_q, uf_n;
  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n, src_l_q, src_l_n, dst_l_q, dst_l_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_l_q, cnt_l_n;
  logic [1:0]        rgn, bsel;
  logic              reload;

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic upd, logic dir);
    if (!upd) return a;
    return dir ? a - ADDR_W'(1) : a + ADDR_W'(1);
  endfunction

  assign rgn      = cpu_addr[3:2];
  assign bsel     = cpu_addr[1:0];
  assign cnt_zero = (cnt_q == '0);
  assign reload   = wr_en && (cpu_addr == OFS_MODE) && cpu_wdata[6];

  always_comb begin
    mode_n  = mode_q;
    en_n    = en_q;
    uf_n    = uf_q;
    src_n   = src_q;
    dst_n   = dst_q;
    cnt_n   = cnt_q;
    src_l_n = src_l_q;
    dst_l_n = dst_l_q;
    cnt_l_n = cnt_l_q;
    // transfer update
    if (step) begin
      if (cnt_zero) begin
        cnt_n = cnt_l_q;
        if (inhibit) begin
          src_n = step_addr(src_q, mode_q.src_upd, mode_q.src_dir);
          dst_n = step_addr(dst_q, mode_q.dst_upd, mode_q.dst_dir);
        end else begin
          src_n = src_l_q;
          dst_n = dst_l_q;
        end
        if (mode_q.stop_uf) en_n = 1'b0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
        src_n = step_addr(src_q, mode_q.src_upd, mode_q.src_dir);
        dst_n = step_addr(dst_q, mode_q.dst_upd, mode_q.dst_dir);
      end
    end
    // CPU write
    if (wr_en) begin
      unique case (rgn)
        RGN_SRC: begin
          src_l_n = ADDR_W'(put_byte({{AW_PAD{1'b0}}, src_l_q}, bsel, cpu_wdata));
          if (!mode_q.latch_only)
            src_n = ADDR_W'(put_byte({{AW_PAD{1'b0}}, src_q}, bsel, cpu_wdata));
        end
        RGN_DST: begin
          dst_l_n = ADDR_W'(put_byte({{AW_PAD{1'b0}}, dst_l_q}, bsel, cpu_wdata));
          if (!mode_q.latch_only)
            dst_n = ADDR_W'(put_byte({{AW_PAD{1'b0}}, dst_q}, bsel, cpu_wdata));
        end
        RGN_CNT: begin
          cnt_l_n = CNT_W'(put_byte({{CW_PAD{1'b0}}, cnt_l_q}, bsel, cpu_wdata));
          if (!mode_q.latch_only)
            cnt_n = CNT_W'(put_byte({{CW_PAD{1'b0}}, cnt_q}, bsel, cpu_wdata));
        end
        default: begin
          if (cpu_addr == OFS_MODE) begin
            mode_n = '{burst: cpu_wdata[7], stop_uf: cpu_wdata[5], latch_only: cpu_wdata[4],
                       dst_upd: cpu_wdata[3], dst_dir: cpu_wdata[2],
                       src_upd: cpu_wdata[1], src_dir: cpu_wdata[0]};
          end
          if (cpu_addr == OFS_CTRL) en_n = cpu_wdata[0];
        end
      endcase
    end
    if (reload) begin
      src_n = src_l_q;
      dst_n = dst_l_q;
      cnt_n = cnt_l_q;
    end
    // sticky underflow: a fresh underflow wins over a clear
    if (step && cnt_zero) uf_n = 1'b1;
    else if (uf_clr)      uf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      en_q    <= 1'b0;
      uf_q    <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      src_l_q <= '0;
      dst_l_q <= '0;
      cnt_l_q <= '0;
    end else begin
      mode_q  <= mode_n;
      en_q    <= en_n;
      uf_q    <= uf_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      cnt_q   <= cnt_n;
      src_l_q <= src_l_n;
      dst_l_q <= dst_l_n;
      cnt_l_q <= cnt_l_n;
    end
  end

  always_comb begin
    unique case (rgn)
      RGN_SRC: rd_data = get_byte({{AW_PAD{1'b0}}, src_q}, bsel);
      RGN_DST: rd_data = get_byte({{AW_PAD{1'b0}}, dst_q}, bsel);
      RGN_CNT: rd_data = get_byte({{CW_PAD{1'b0}}, cnt_q}, bsel);
      default: begin
        if (cpu_addr == OFS_MODE)
          rd_data = {mode_q.burst, 1'b0, mode_q.stop_uf, mode_q.latch_only,
                     mode_q.dst_upd, mode_q.dst_dir, mode_q.src_upd, mode_q.src_dir};
        else if (cpu_addr == OFS_CTRL)
          rd_data = {7'd0, en_q};
        else
          rd_data = 8'd0;
      end
    endcase
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign en_o    = en_q;
  assign burst_o = mode_q.burst;
  assign uf_o    = uf_q;

  a_r7_uf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_zero) |=> uf_q);

  a_r7_cnt_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_zero && !wr_en) |=> (cnt_q == $past(cnt_l_q)));

  a_r8_stop_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_zero && mode_q.stop_uf && !wr_en) |=> !en_q);

  a_r6_reload_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !step) |=> (src_q == $past(src_l_q) && dst_q == $past(dst_l_q)));

  a_r5_latch_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rgn == RGN_SRC && mode_q.latch_only && !step) |=> $stable(src_q));
endmodule

// File: rtl/dma2ch_seq.sv
module dma2ch_seq
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             req_i,
  input  logic [NCH-1:0]             en_i,
  input  logic [NCH-1:0]             burst_i,
  input  logic [NCH-1:0]             cnt_zero_i,
  input  logic [NCH-1:0][ADDR_W-1:0] src_i,
  input  logic [NCH-1:0][ADDR_W-1:0] dst_i,
  input  logic                       irq_busy_i,
  input  logic                       susp_all_i,
  input  logic                       bus_gnt_i,
  input  logic [7:0]                 bus_rdata_i,
  output logic                       bus_req_o,
  output logic                       bus_rd_o,
  output logic                       bus_wr_o,
  output logic [ADDR_W-1:0]          bus_addr_o,
  output logic [7:0]                 bus_wdata_o,
  output logic [NCH-1:0]             step_o,
  output logic [NCH-1:0]             susp_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e      state_q, state_n;
  logic [CH_W-1:0] cur_q, cur_n;
  logic            burst_on_q, burst_on_n;
  logic [NCH-1:0]  pend_q, pend_n, wants, blocked, go, clr;
  logic [7:0]      data_q, data_n;
  logic            picked;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      wants[c]   = en_i[c] && (pend_q[c] || (burst_on_q && cur_q == CH_W'(c)));
      blocked[c] = irq_busy_i && (burst_i[c] || susp_all_i);
      go[c]      = wants[c] && !blocked[c];
    end
  end

  always_comb begin
    state_n    = state_q;
    cur_n      = cur_q;
    burst_on_n = burst_on_q;
    data_n     = data_q;
    clr        = '0;
    step_o     = '0;
    picked     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (burst_on_q) begin
          if (!en_i[cur_q])   burst_on_n = 1'b0;
          else if (go[cur_q]) state_n = SQ_REQ;
        end else begin
          // lowest channel number wins
          for (int c = 0; c < NCH; c++) begin
            if (go[c] && !picked) begin
              picked     = 1'b1;
              cur_n      = CH_W'(c);
              clr[c]     = 1'b1;
              burst_on_n = burst_i[c];
              state_n    = SQ_REQ;
            end
          end
        end
      end
      SQ_REQ: if (bus_gnt_i) state_n = SQ_RD;
      SQ_RD: begin
        data_n  = bus_rdata_i;
        state_n = SQ_WR;
      end
      SQ_WR: begin
        step_o[cur_q] = 1'b1;
        if (burst_on_q && cnt_zero_i[cur_q]) burst_on_n = 1'b0;
        state_n = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
    pend_n = ((pend_q & ~clr) | req_i) & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cur_q      <= '0;
      burst_on_q <= 1'b0;
      pend_q     <= '0;
      data_q     <= '0;
    end else begin
      state_q    <= state_n;
      cur_q      <= cur_n;
      burst_on_q <= burst_on_n;
      pend_q     <= pend_n;
      data_q     <= data_n;
    end
  end

  assign bus_req_o   = (state_q != SQ_IDLE);
  assign bus_rd_o    = (state_q == SQ_RD);
  assign bus_wr_o    = (state_q == SQ_WR);
  assign bus_wdata_o = data_q;
  assign susp_o      = wants & blocked;

  always_comb begin
    if (state_q == SQ_RD)      bus_addr_o = src_i[cur_q];
    else if (state_q == SQ_WR) bus_addr_o = dst_i[cur_q];
    else                       bus_addr_o = '0;
  end

  a_r13_grant_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> $past(bus_req_o && bus_gnt_i));

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |=> bus_wr_o);

  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd_o, bus_wr_o}));

  a_r13_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i && !bus_rd_o && !bus_wr_o) |=> bus_req_o);

  a_r11_burst_keeps_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on_q && state_q != SQ_WR) |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [1:0]        dma_req,
  input  logic              irq_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata
);
  localparam int NCH = 2;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       susp_all_q, susp_all_n, inhibit_q, inhibit_n, idx_q, idx_n;
  logic       stat_wr;

  logic [NCH-1:0]             ch_wr, uf_clr, step, cnt_zero, en, burst, uf, susp;
  logic [NCH-1:0][ADDR_W-1:0] src, dst;
  logic [NCH-1:0][7:0]        ch_rdata;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign stat_wr = cpu_we && (cpu_addr == OFS_STAT);

  always_comb begin
    susp_all_n = susp_all_q;
    inhibit_n  = inhibit_q;
    idx_n      = idx_q;
    if (stat_wr) begin
      susp_all_n = cpu_wdata[4];
      inhibit_n  = cpu_wdata[5];
      idx_n      = cpu_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      susp_all_q <= 1'b0;
      inhibit_q  <= 1'b0;
      idx_q      <= 1'b0;
    end else begin
      susp_all_q <= susp_all_n;
      inhibit_q  <= inhibit_n;
      idx_q      <= idx_n;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wr[c]  = cpu_we && (cpu_addr != OFS_STAT) && (idx_q == 1'(c));
    assign uf_clr[c] = stat_wr && !cpu_wdata[2*c];

    dma2ch_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .wr_en    (ch_wr[c]),
      .cpu_addr (cpu_addr),
      .cpu_wdata(cpu_wdata),
      .step     (step[c]),
      .inhibit  (inhibit_q),
      .uf_clr   (uf_clr[c]),
      .rd_data  (ch_rdata[c]),
      .src_o    (src[c]),
      .dst_o    (dst[c]),
      .cnt_zero (cnt_zero[c]),
      .en_o     (en[c]),
      .burst_o  (burst[c]),
      .uf_o     (uf[c])
    );
  end

  dma2ch_seq #(.ADDR_W(ADDR_W), .NCH(NCH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_i      (dma_req),
    .en_i       (en),
    .burst_i    (burst),
    .cnt_zero_i (cnt_zero),
    .src_i      (src),
    .dst_i      (dst),
    .irq_busy_i (irq_busy),
    .susp_all_i (susp_all_q),
    .bus_gnt_i  (bus_gnt),
    .bus_rdata_i(bus_rdata),
    .bus_req_o  (bus_req),
    .bus_rd_o   (bus_rd),
    .bus_wr_o   (bus_wr),
    .bus_addr_o (bus_addr),
    .bus_wdata_o(bus_wdata),
    .step_o     (step),
    .susp_o     (susp)
  );

  always_comb begin
    if (cpu_addr == OFS_STAT)
      cpu_rdata = {idx_q, 1'b0, inhibit_q, susp_all_q, susp[1], uf[1], susp[0], uf[0]};
    else
      cpu_rdata = ch_rdata[idx_q];
  end

  a_r13_release_after_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_wr |=> !bus_req);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> !bus_req);

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_wr |-> $past(bus_rd));
endmodule

// File: tb/sim_dma2ch_engine.sv
module sim_dma2ch_engine;
  logic        clk, rst_n, cpu_we, irq_busy, bus_req, bus_gnt, bus_rd, bus_wr;
  logic [3:0]  cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata, bus_wdata, bus_rdata;
  logic [1:0]  dma_req;
  logic [15:0] bus_addr;

  logic [7:0]  mem [0:255];
  int          wr_order [0:255];
  int          wr_count, rd_seen;
  logic [15:0] first_rd;
  logic        gnt_allow, ctl_sall, ctl_inh, finished;
  int          n_tests, n_fail;

  dma2ch_engine u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dma_req(dma_req), .irq_busy(irq_busy), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign bus_gnt   = bus_req && gnt_allow;
  assign bus_rdata = mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (bus_wr) begin
      mem[bus_addr[7:0]] <= bus_wdata;
      wr_count = wr_count + 1;
      wr_order[bus_addr[7:0]] = wr_count;
    end
    if (bus_rd) begin
      if (rd_seen == 0) first_rd <= bus_addr;
      rd_seen = rd_seen + 1;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = pat(i);
      wr_order[i] = 0;
    end
    wr_count = 0;
    rd_seen  = 0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic wstat(logic ch);
    cpu_wr(4'd0, {ch, 1'b0, ctl_inh, ctl_sall, 4'b0000});
  endtask

  task automatic rd16(logic ch, logic [3:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    wstat(ch);
    cpu_rd(base, lo);
    cpu_rd(base + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setup(logic ch, logic [7:0] m1, logic [15:0] s, logic [15:0] d, logic [15:0] n);
    wstat(ch);
    cpu_wr(4'd2, 8'h00);
    cpu_wr(4'd1, m1 & 8'hAF);
    cpu_wr(4'd4, s[7:0]);  cpu_wr(4'd5, s[15:8]);
    cpu_wr(4'd8, d[7:0]);  cpu_wr(4'd9, d[15:8]);
    cpu_wr(4'd12, n[7:0]); cpu_wr(4'd13, n[15:8]);
    cpu_wr(4'd1, m1 & 8'hBF);
    cpu_wr(4'd2, 8'h01);
  endtask

  task automatic pulse(logic [1:0] m);
    @(negedge clk) dma_req = m;
    @(negedge clk) dma_req = 2'b00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    cpu_rd(4'd0, d);  chk("R1 status", d, 8'h00);
    cpu_rd(4'd2, d);  chk("R1 ch0 enable", d, 8'h00);
    chk("R1 bus_req", bus_req, 1'b0);
  endtask

  task automatic t_cycle_steal();
    logic [15:0] v; logic [7:0] d;
    init_mem();
    setup(1'b0, 8'h0A, 16'h0010, 16'h0080, 16'd2);
    pulse(2'b01); idle(12);
    chk("R3 one byte", mem[8'h80], pat(8'h10));
    chk("R3 only one", mem[8'h81], pat(8'h81));
    rd16(1'b0, 4'd4, v);  chk("R4 src inc", v, 16'h0011);
    rd16(1'b0, 4'd8, v);  chk("R4 dst inc", v, 16'h0081);
    rd16(1'b0, 4'd12, v); chk("R4 count dec", v, 16'd1);
    pulse(2'b01); idle(12);
    pulse(2'b01); idle(12);
    chk("R7 third byte", mem[8'h82], pat(8'h12));
    cpu_rd(4'd0, d);  chk("R7 uf flag set", d[0], 1'b1);
    cpu_rd(4'd2, d);  chk("R8 stays enabled", d[0], 1'b1);
    rd16(1'b0, 4'd4, v);  chk("R7 src reload", v, 16'h0010);
    rd16(1'b0, 4'd8, v);  chk("R7 dst reload", v, 16'h0080);
    rd16(1'b0, 4'd12, v); chk("R7 count reload", v, 16'd2);
    cpu_rd(4'd0, d);  chk("R7 uf cleared by 0", d[0], 1'b0);
  endtask

  task automatic t_directions();
    logic [15:0] v;
    init_mem();
    setup(1'b0, 8'h03, 16'h0030, 16'h0090, 16'd5);
    pulse(2'b01); idle(12);
    pulse(2'b01); idle(12);
    chk("R4 fixed dst, dec src data", mem[8'h90], pat(8'h2F));
    rd16(1'b0, 4'd4, v);  chk("R4 src dec", v, 16'h002E);
    rd16(1'b0, 4'd8, v);  chk("R4 dst hold", v, 16'h0090);
    rd16(1'b0, 4'd12, v); chk("R4 count", v, 16'd3);
  endtask

  task automatic t_latch_reload();
    logic [7:0] d; logic [15:0] v;
    init_mem();
    setup(1'b1, 8'h0A, 16'h0040, 16'h00A0, 16'd3);
    cpu_wr(4'd1, 8'h1A);
    cpu_wr(4'd4, 8'h50);
    cpu_wr(4'd12, 8'h07);
    cpu_rd(4'd4, d);  chk("R5 src working kept", d, 8'h40);
    cpu_rd(4'd12, d); chk("R5 count working kept", d, 8'h03);
    cpu_wr(4'd1, 8'h5A);
    cpu_rd(4'd4, d);  chk("R6 src reloaded", d, 8'h50);
    cpu_rd(4'd12, d); chk("R6 count reloaded", d, 8'h07);
    cpu_rd(4'd1, d);  chk("R6 reload reads 0", d, 8'h1A);
    pulse(2'b10); idle(12);
    chk("R6 moves from new src", mem[8'hA0], pat(8'h50));
    rd16(1'b0, 4'd4, v); chk("R2 ch0 untouched", v, 16'h002E);
  endtask

  task automatic t_burst();
    logic [7:0] d; logic [15:0] v;
    init_mem();
    setup(1'b0, 8'h8A, 16'h0020, 16'h00C0, 16'd3);
    pulse(2'b01); idle(40);
    for (int i = 0; i < 4; i++) chk("R9 burst byte", mem[8'hC0 + i], pat(8'h20 + i));
    chk("R9 stops at underflow", mem[8'hC4], pat(8'hC4));
    cpu_rd(4'd0, d); chk("R9 uf flag", d[0], 1'b1);
    rd16(1'b0, 4'd12, v); chk("R9 count reloaded", v, 16'd3);
  endtask

  task automatic t_stop_uf();
    logic [7:0] d; logic [15:0] v;
    init_mem();
    setup(1'b1, 8'h2A, 16'h0060, 16'h00D0, 16'd0);
    pulse(2'b10); idle(12);
    chk("R8 byte moved", mem[8'hD0], pat(8'h60));
    cpu_rd(4'd2, d); chk("R8 enable cleared", d[0], 1'b0);
    pulse(2'b10); idle(12);
    chk("R8 request ignored", mem[8'hD1], pat(8'hD1));
    rd16(1'b1, 4'd4, v); chk("R8 src unchanged", v, 16'h0060);
  endtask

  task automatic t_inhibit();
    logic [15:0] v;
    init_mem();
    ctl_inh = 1'b1;
    setup(1'b0, 8'h0A, 16'h0070, 16'h00E0, 16'd0);
    pulse(2'b01); idle(12);
    rd16(1'b0, 4'd4, v);  chk("R10 src not reloaded", v, 16'h0071);
    rd16(1'b0, 4'd8, v);  chk("R10 dst not reloaded", v, 16'h00E1);
    rd16(1'b0, 4'd12, v); chk("R10 count reloaded", v, 16'd0);
    ctl_inh = 1'b0;
    wstat(1'b0);
  endtask

  task automatic t_priority();
    init_mem();
    setup(1'b0, 8'h0A, 16'h0011, 16'h00F0, 16'd5);
    setup(1'b1, 8'h0A, 16'h0022, 16'h00F8, 16'd5);
    rd_seen = 0;
    pulse(2'b11); idle(20);
    chk("R11 ch0 first", first_rd, 16'h0011);
    chk("R11 ch0 moved", mem[8'hF0], pat(8'h11));
    chk("R11 ch1 moved", mem[8'hF8], pat(8'h22));
    init_mem();
    setup(1'b0, 8'h8A, 16'h0000, 16'h00B0, 16'd3);
    setup(1'b1, 8'h0A, 16'h0033, 16'h00B8, 16'd5);
    pulse(2'b01);
    pulse(2'b10);
    idle(40);
    chk("R11 ch1 served", mem[8'hB8], pat(8'h33));
    chk("R11 burst not preempted", 32'(wr_order[8'hB8] > wr_order[8'hB3]), 32'd1);
  endtask

  task automatic t_suspend();
    logic [7:0] d;
    init_mem();
    setup(1'b0, 8'h8A, 16'h0000, 16'h0040, 16'd1);
    setup(1'b1, 8'h0A, 16'h0010, 16'h0050, 16'd4);
    @(negedge clk) irq_busy = 1'b1;
    pulse(2'b11); idle(20);
    chk("R12 cycle steal runs", mem[8'h50], pat(8'h10));
    chk("R12 burst held", mem[8'h40], pat(8'h40));
    cpu_rd(4'd0, d);
    chk("R12 ch0 suspended flag", d[1], 1'b1);
    chk("R12 ch1 not suspended", d[3], 1'b0);
    ctl_sall = 1'b1;
    wstat(1'b1);
    pulse(2'b10); idle(20);
    chk("R12 cycle steal held", mem[8'h51], pat(8'h51));
    cpu_rd(4'd0, d);
    chk("R12 ch1 suspended flag", d[3], 1'b1);
    @(negedge clk) irq_busy = 1'b0;
    idle(40);
    chk("R12 burst resumes b0", mem[8'h40], pat(8'h00));
    chk("R12 burst resumes b1", mem[8'h41], pat(8'h01));
    chk("R12 ch1 resumes", mem[8'h51], pat(8'h11));
    cpu_rd(4'd0, d);
    chk("R12 flags clear", {d[3], d[1]}, 2'b00);
    ctl_sall = 1'b0;
    wstat(1'b0);
  endtask

  task automatic t_grant();
    init_mem();
    setup(1'b0, 8'h0A, 16'h0005, 16'h0060, 16'd5);
    @(negedge clk) gnt_allow = 1'b0;
    rd_seen = 0;
    pulse(2'b01); idle(10);
    chk("R13 req held", bus_req, 1'b1);
    chk("R13 no read w/o grant", rd_seen, 0);
    chk("R13 no write w/o grant", mem[8'h60], pat(8'h60));
    @(negedge clk) gnt_allow = 1'b1;
    idle(10);
    chk("R13 moved after grant", mem[8'h60], pat(8'h05));
    chk("R13 bus released", bus_req, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    finished = 1'b0; n_tests = 0; n_fail = 0;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    dma_req = '0; irq_busy = 1'b0; gnt_allow = 1'b1;
    ctl_sall = 1'b0; ctl_inh = 1'b0;
    init_mem();
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    t_reset();
    t_cycle_steal();
    t_directions();
    t_latch_reload();
    t_burst();
    t_stop_uf();
    t_inhibit();
    t_priority();
    t_suspend();
    t_grant();
    finish_run();
  end
endmodule